// File: doc/BRIEF.md
# Dual-Mode LCD Horizontal Line Timing Generator

This block produces the horizontal timing of one display line, over and over, for a panel controller that serves either an active-matrix panel or a passive-matrix panel. A single phase counter walks each line through four phases: line sync, leading gap, active data and trailing gap. In active-matrix mode every phase is counted in pixel-clock periods, which are marked by the `pix_en` strobe. In passive-matrix mode the sync, the leading delay and the trailing blank are counted in system clocks. Only the active phase follows `pix_en`. The leading delay is one of four coded values and the blank is set in steps of eight clocks.

A 32-bit configuration word carries three fields: leading gap, line size and trailing gap. The word is captured together with the mode and the sync width only when a line begins, so software may rewrite it at any time. The line size must give a line of a whole number of 32-bit words (for example 128 pixels rather than 120 at one bit per pixel). The panel drops any surplus pixels. This block does not check that rule. A separate check raises a flag when a passive-matrix setup leaves too little line overhead for the slowest memory access time, which is given on the `tmax` input.

Top module: `hline_timing_gen`

## Requirements
- R1: After reset, `line_sync_n`=1, `active`=0, `shift_gate`=0 and `cfg_err`=0.
- R2: Field positions in `cfg_word`: leading gap in bits [25:19], line size in bits [18:8], trailing gap in bits [7:0]. In active-matrix mode (`stn_mode`=0), sync lasts `sync_w`+1 units, the leading gap lasts field+1 units, the active phase lasts size+1 units and the trailing gap lasts field+1 units.
- R3: A line runs sync (`line_sync_n`=0), leading gap, active, trailing gap, and then starts again at sync. In active-matrix mode a unit is one clock with `pix_en`=1, and the counter holds on clocks with `pix_en`=0.
- R4: `active` is 1 exactly during the active phase, and never together with `line_sync_n`=0.
- R5: In passive-matrix mode (`stn_mode`=1), sync lasts `sync_w`+1 system clocks. The leading delay lasts 16×(bits[20:19]+1) system clocks, and bits [25:21] have no effect. The active phase counts size+1 clocks with `pix_en`=1.
- R6: In passive-matrix mode, the trailing blank lasts 8×bits[7:0] system clocks, and a value of 0 removes the blank. In that mode `shift_gate` is 1 only during the active phase. In active-matrix mode `shift_gate` is 1 whenever a line is running.
- R7: The configuration word, `stn_mode` and `sync_w` are captured on the clock edge that starts a line. A change in the middle of a line alters only the following lines.
- R8: `cfg_err` follows its inputs one clock later. It is 1 exactly when `stn_mode`=1 and 8×blank + (`sync_w`+1) + 16×(bits[20:19]+1) ≤ 14 + 12×`tmax`.
- R9: With `enable`=0 the outputs return to the reset levels on the next edge. The first edge with `enable`=1 starts a line at sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the line sequence |
| stn_mode | input | 1 | 1 = passive-matrix timing, 0 = active-matrix timing |
| cfg_word | input | 32 | Gap, size and blank fields |
| sync_w | input | SWW | Sync width minus one, in units |
| tmax | input | TMW | Slowest memory access time, in clocks |
| pix_en | input | 1 | Pixel-clock period strobe |
| line_sync_n | output | 1 | Line sync, active low |
| active | output | 1 | Active-data window |
| shift_gate | output | 1 | Shift-clock permit |
| cfg_err | output | 1 | Passive-matrix overhead too short |

## Verification
The two functions that can meet in one cycle are the capture of the configuration at a line start and a software rewrite of that same word. The end of a line can also meet a change of `stn_mode`. Long runs with random `pix_en` rewrite the word, the mode and the sync width at random clocks, so some rewrites land exactly on the capture edge and others land mid-line. A behavioural model in the bench is compared with all four outputs on every clock. Directed cases also measure phase lengths when the word is rewritten in the middle of an active phase.

// File: rtl/hline_pkg.sv
package hline_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_LEAD  = 3'd2,
    PH_ACT   = 3'd3,
    PH_TRAIL = 3'd4
  } phase_t;

  localparam int LEAD_LO  = 19;
  localparam int LEAD_W   = 7;
  localparam int SIZE_LO  = 8;
  localparam int SIZE_W   = 11;
  localparam int TRAIL_LO = 0;
  localparam int TRAIL_W  = 8;
  localparam int DLY_W    = 2;
  localparam int DLY_STEP = 16;
  localparam int BLK_STEP = 8;
endpackage

// File: rtl/hline_cfg_latch.sv
module hline_cfg_latch
  import hline_pkg::*;
#(
  parameter int CW  = 12,
  parameter int SWW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [31:0]    cfg_word,
  input  logic           stn_in,
  input  logic [SWW-1:0] sync_w,
  output logic           stn_q,
  output logic [CW-1:0]  len_sync,
  output logic [CW-1:0]  len_lead,
  output logic [CW-1:0]  len_act,
  output logic [CW-1:0]  len_trail
);
  logic [CW-1:0] n_sync, n_lead, n_act, n_trail;

  always_comb begin
    n_sync = CW'(sync_w) + CW'(1);
    n_act  = CW'(cfg_word[SIZE_LO +: SIZE_W]) + CW'(1);
    if (stn_in) begin
      n_lead  = (CW'(cfg_word[LEAD_LO +: DLY_W]) + CW'(1)) * CW'(DLY_STEP);
      n_trail = CW'(cfg_word[TRAIL_LO +: TRAIL_W]) * CW'(BLK_STEP);
    end else begin
      n_lead  = CW'(cfg_word[LEAD_LO +: LEAD_W]) + CW'(1);
      n_trail = CW'(cfg_word[TRAIL_LO +: TRAIL_W]) + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stn_q     <= 1'b0;
      len_sync  <= CW'(1);
      len_lead  <= CW'(1);
      len_act   <= CW'(1);
      len_trail <= CW'(1);
    end else if (load) begin
      stn_q     <= stn_in;
      len_sync  <= n_sync;
      len_lead  <= n_lead;
      len_act   <= n_act;
      len_trail <= n_trail;
    end
  end
endmodule

// File: rtl/hline_seq.sv
module hline_seq
  import hline_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          pix_en,
  input  logic          stn_q,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_lead,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_trail,
  output phase_t        phase,
  output logic          load
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_len;
  logic          step, last, no_trail;
  phase_t        nxt;

  always_comb begin
    case (phase)
      PH_SYNC:  cur_len = len_sync;
      PH_LEAD:  cur_len = len_lead;
      PH_ACT:   cur_len = len_act;
      PH_TRAIL: cur_len = len_trail;
      default:  cur_len = CW'(1);
    endcase
  end

  assign step     = (stn_q && phase != PH_ACT) ? 1'b1 : pix_en;
  assign last     = (cnt == cur_len - CW'(1));
  assign no_trail = (len_trail == '0);

  always_comb begin
    nxt  = phase;
    load = 1'b0;
    if (!enable) begin
      nxt = PH_IDLE;
    end else if (phase == PH_IDLE) begin
      nxt  = PH_SYNC;
      load = 1'b1;
    end else if (step && last) begin
      case (phase)
        PH_SYNC: nxt = PH_LEAD;
        PH_LEAD: nxt = PH_ACT;
        PH_ACT: begin
          nxt  = no_trail ? PH_SYNC : PH_TRAIL;
          load = no_trail;
        end
        default: begin
          nxt  = PH_SYNC;
          load = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nxt;
      if (nxt != phase || !enable) cnt <= '0;
      else if (step)               cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/hline_cfg_check.sv
module hline_cfg_check
  import hline_pkg::*;
#(
  parameter int SWW = 4,
  parameter int TMW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stn_mode,
  input  logic [31:0]    cfg_word,
  input  logic [SWW-1:0] sync_w,
  input  logic [TMW-1:0] tmax,
  output logic           cfg_err
);
  localparam int EW = 16;
  logic [EW-1:0] overhead, budget;

  always_comb begin
    overhead = EW'(cfg_word[TRAIL_LO +: TRAIL_W]) * EW'(BLK_STEP)
             + EW'(sync_w) + EW'(1)
             + (EW'(cfg_word[LEAD_LO +: DLY_W]) + EW'(1)) * EW'(DLY_STEP);
    budget   = EW'(14) + EW'(12) * EW'(tmax);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= stn_mode && (overhead <= budget);
  end
endmodule

// File: rtl/hline_timing_gen.sv
module hline_timing_gen
  import hline_pkg::*;
#(
  parameter int SWW = 4,
  parameter int TMW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           stn_mode,
  input  logic [31:0]    cfg_word,
  input  logic [SWW-1:0] sync_w,
  input  logic [TMW-1:0] tmax,
  input  logic           pix_en,
  output logic           line_sync_n,
  output logic           active,
  output logic           shift_gate,
  output logic           cfg_err
);
  localparam int CW = SIZE_W + 1;

  logic          load, stn_q;
  logic [CW-1:0] len_sync, len_lead, len_act, len_trail;
  phase_t        phase;

  hline_cfg_latch #(.CW(CW), .SWW(SWW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_word(cfg_word),
    .stn_in(stn_mode), .sync_w(sync_w), .stn_q(stn_q),
    .len_sync(len_sync), .len_lead(len_lead), .len_act(len_act),
    .len_trail(len_trail)
  );

  hline_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pix_en(pix_en),
    .stn_q(stn_q), .len_sync(len_sync), .len_lead(len_lead),
    .len_act(len_act), .len_trail(len_trail), .phase(phase), .load(load)
  );

  hline_cfg_check #(.SWW(SWW), .TMW(TMW)) u_check (
    .clk(clk), .rst_n(rst_n), .stn_mode(stn_mode), .cfg_word(cfg_word),
    .sync_w(sync_w), .tmax(tmax), .cfg_err(cfg_err)
  );

  assign line_sync_n = (phase != PH_SYNC);
  assign active      = (phase == PH_ACT);
  assign shift_gate  = (phase != PH_IDLE) && (!stn_q || phase == PH_ACT);
endmodule

// File: rtl/hline_timing_chk.sv
module hline_timing_chk #(
  parameter int SWW = 4,
  parameter int TMW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           stn_mode,
  input logic [31:0]    cfg_word,
  input logic [SWW-1:0] sync_w,
  input logic [TMW-1:0] tmax,
  input logic           pix_en,
  input logic           line_sync_n,
  input logic           active,
  input logic           shift_gate,
  input logic           cfg_err
);
  assert_act_no_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> line_sync_n);

  assert_act_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> shift_gate);

  assert_sync_then_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_sync_n) && $past(enable)) |-> !active);

  assert_err_tft_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stn_mode |=> !cfg_err);

  assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (line_sync_n && !active && !shift_gate));
endmodule

bind hline_timing_gen hline_timing_chk #(.SWW(SWW), .TMW(TMW)) u_chk (.*);

// File: tb/test_hline_timing_gen.sv
module test_hline_timing_gen;
  localparam int SWW = 4;
  localparam int TMW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           enable = 1'b0;
  logic           stn_mode = 1'b0;
  logic [31:0]    cfg_word = '0;
  logic [SWW-1:0] sync_w = '0;
  logic [TMW-1:0] tmax = '0;
  logic           pix_en = 1'b0;
  logic           line_sync_n, active, shift_gate, cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hline_timing_gen #(.SWW(SWW), .TMW(TMW)) i_hline_timing_gen (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int lead, input int size, input int trail);
    return {6'b0, 7'(lead), 11'(size), 8'(trail)};
  endfunction

  // behavioural reference model
  int  mph = 0, mcnt = 0, mstn = 0;
  int  ml[5];
  bit  merr = 0;
  bit  cmp_on = 0;

  function automatic void mload();
    mstn  = stn_mode;
    ml[1] = int'(sync_w) + 1;
    ml[3] = int'(cfg_word[18:8]) + 1;
    if (stn_mode) begin
      ml[2] = 16 * (int'(cfg_word[20:19]) + 1);
      ml[4] = 8 * int'(cfg_word[7:0]);
    end else begin
      ml[2] = int'(cfg_word[25:19]) + 1;
      ml[4] = int'(cfg_word[7:0]) + 1;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mstn = 0; merr = 0;
    end else begin
      merr = stn_mode && (8 * int'(cfg_word[7:0]) + int'(sync_w) + 1
             + 16 * (int'(cfg_word[20:19]) + 1) <= 14 + 12 * int'(tmax));
      if (!enable) begin
        mph = 0; mcnt = 0;
      end else if (mph == 0) begin
        mload(); mph = 1; mcnt = 0;
      end else if ((mstn && mph != 3) || pix_en) begin
        if (mcnt + 1 >= ml[mph]) begin
          mcnt = 0;
          if (mph == 3 && ml[4] == 0) begin mload(); mph = 1; end
          else if (mph == 4)          begin mload(); mph = 1; end
          else mph = mph + 1;
        end else mcnt = mcnt + 1;
      end
    end
  end

  always @(negedge clk) if (cmp_on && rst_n) begin
    check(line_sync_n == (mph != 1), "R3 line_sync_n", line_sync_n, mph != 1);
    check(active == (mph == 3), "R4 active", active, mph == 3);
    check(shift_gate == (mph != 0 && (mstn == 0 || mph == 3)), "R6 shift_gate",
          shift_gate, mph != 0 && (mstn == 0 || mph == 3));
    check(cfg_err == merr, "R8 cfg_err", cfg_err, merr);
  end

  task automatic random_run(input int cycles, input bit stn, input int trail_max);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      pix_en = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 40) == 0) begin
        cfg_word = mk($urandom_range(0, 127), $urandom_range(0, 15),
                      $urandom_range(0, trail_max));
        sync_w   = SWW'($urandom_range(0, 3));
        tmax     = TMW'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 150) == 0) stn_mode = ~stn_mode;
      else if ($urandom_range(0, 150) == 0) stn_mode = stn;
    end
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset levels
    check(line_sync_n == 1'b1, "R1 sync idle", line_sync_n, 1);
    check(active == 1'b0, "R1 active idle", active, 0);
    check(shift_gate == 1'b0, "R1 gate idle", shift_gate, 0);
    check(cfg_err == 1'b0, "R1 err idle", cfg_err, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);

    // R2/R3 active-matrix phase lengths with pix_en held high
    stn_mode = 0; sync_w = 2; cfg_word = mk(3, 7, 1); pix_en = 1; enable = 1;
    while (line_sync_n) @(negedge clk);
    n = 0; while (!line_sync_n) begin n++; @(negedge clk); end
    check(n == 3, "R2 sync length", n, 3);
    n = 0; while (!active) begin n++; @(negedge clk); end
    check(n == 4, "R2 lead length", n, 4);
    n = 0; while (active) begin n++; @(negedge clk); end
    check(n == 8, "R4 active length", n, 8);
    n = 0; while (line_sync_n) begin n++; @(negedge clk); end
    check(n == 2, "R2 trail length", n, 2);

    // R3 random pix_en, active-matrix
    random_run(3000, 1'b0, 7);

    // R5 passive-matrix delay, upper delay bits set
    enable = 0; @(negedge clk);
    stn_mode = 1; sync_w = 3; tmax = 0; pix_en = 1;
    cfg_word = mk(7'b1111101, 15, 2); enable = 1;
    @(negedge clk);
    while (line_sync_n) @(negedge clk);
    n = 0; while (!line_sync_n) begin n++; @(negedge clk); end
    check(n == 4, "R5 stn sync length", n, 4);
    n = 0; while (!shift_gate) begin n++; @(negedge clk); end
    check(n == 32, "R5 stn delay ignores upper bits", n, 32);
    while (shift_gate) @(negedge clk);
    n = 0; while (line_sync_n && !shift_gate) begin n++; @(negedge clk); end
    check(n == 16, "R6 stn blank length", n, 16);
    check(cfg_err == 1'b0, "R8 err low", cfg_err, 0);
    tmax = 5; @(negedge clk);
    check(cfg_err == 1'b1, "R8 err high", cfg_err, 1);
    tmax = 0;

    // R6 zero blank: sync follows active directly
    cfg_word = mk(0, 5, 0);
    while (!active) @(negedge clk);
    while (!active) @(negedge clk);
    while (active) @(negedge clk);
    while (!active) @(negedge clk);
    while (active) @(negedge clk);
    check(line_sync_n == 1'b0, "R6 no blank", line_sync_n, 0);

    // passive-matrix random runs
    random_run(3000, 1'b1, 3);

    // R7 mid-line rewrite affects only next line
    enable = 0; @(negedge clk);
    stn_mode = 0; sync_w = 0; pix_en = 1; cfg_word = mk(1, 20, 1); enable = 1;
    while (!active) @(negedge clk);
    cfg_word = mk(1, 3, 1);
    n = 0; while (active) begin n++; @(negedge clk); end
    check(n == 21, "R7 current line kept", n, 21);
    while (!active) @(negedge clk);
    n = 0; while (active) begin n++; @(negedge clk); end
    check(n == 4, "R7 next line updated", n, 4);

    // R9 enable drop mid-line
    while (!active) @(negedge clk);
    enable = 0; @(negedge clk);
    check(!active && line_sync_n && !shift_gate, "R9 idle after disable",
          {active, line_sync_n, shift_gate}, 3'b010);
    enable = 1; @(negedge clk);
    check(line_sync_n == 1'b0, "R9 restart at sync", line_sync_n, 0);

    random_run(2000, 1'b0, 7);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule